// File: doc/BRIEF.md
# Locomotive Speed Command Decoder

This block sits behind a track-packet receiver that has already checked framing and the error byte. It keeps the motor-control state of one locomotive: speed step, travel direction, headlight and an emergency-stop flag. The block takes one three-byte packet per cycle in which `pkt_valid` is high. It works out whether the packet is a decoder reset, an idle filler, a broadcast stop or a speed-and-direction instruction for its own short address. It then updates its registered outputs on that clock edge.

The speed instruction is read in one of two modes, selected by `mode_28`. In the 28-step mode, bit 4 of the instruction becomes the least significant bit of a 5-bit speed code. In the 14-step mode, bit 4 sets the headlight and only the low nibble gives the speed. Stop and emergency stop have their own codes in both modes. An emergency stop raises `estop` and holds the speed at zero until a later command asks for a moving step.

Top module: `loco_cmd_decoder`

## Requirements
- R1: A packet acts only when `pkt_valid` is 1, `pkt_len` is 3, `pkt_b0[7]` is 0, `pkt_b0[6:0]` equals a nonzero `cfg_addr`, and `pkt_b1[7:6]` is `01`. Any other packet leaves every output unchanged, except for the special packets in R6 to R8. This covers a different address, another length, a cycle with `pkt_valid` low, and an instruction whose top two bits are not `01`.
- R2: In an acted-on instruction, bit 5 of `pkt_b1` sets `dir_fwd`: 1 means forward and 0 means reverse. The exception is given in R9.
- R3: With `mode_28`=1 the speed code is {`pkt_b1[3:0]`, `pkt_b1[4]`}. Codes 0 and 1 stop the locomotive (speed 0). Codes 2 and 3 are an emergency stop. Codes 4 to 31 give `speed_step` = code − 3, which is 1 to 28.
- R4: With `mode_28`=0, `pkt_b1[4]` is copied to `headlight`. A nibble `pkt_b1[3:0]` of 0 means stop and 1 means emergency stop. Values 2 to 15 give `speed_step` = nibble − 1, which is 1 to 14. In the 28-step mode `headlight` is not changed.
- R5: An emergency stop sets `estop` and forces `speed_step` to 0. Any command that gives a nonzero step clears `estop`. A normal stop leaves `estop` as it was. While `estop` is 1, `speed_step` is 0.
- R6: A reset packet (all three bytes 0x00) sets the power-up state: `speed_step` 0, `dir_fwd` equal to `PWRUP_FWD` (default 1), `headlight` 0 and `estop` 0.
- R7: An idle packet (0xFF, 0x00, 0xFF) changes nothing.
- R8: A broadcast stop has `pkt_b0`=0x00, `pkt_b1`=`01DC000S` and any `pkt_b2`. It sets `speed_step` to 0 whatever `cfg_addr` is. If S is 1 it also sets `estop`; if S is 0, `estop` keeps its value. `dir_fwd` and `headlight` keep their values.
- R9: In the 28-step mode, stop and emergency-stop codes with the C bit (`pkt_b1[4]`) set, which are codes 1 and 3, leave `dir_fwd` unchanged.
- R10: All outputs are registered. They take their new value at the first rising clock edge at which the packet is present. An active-low reset gives the power-up state of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A checked packet is present this cycle |
| pkt_len | input | LEN_W (3) | Number of bytes in the packet |
| pkt_b0 | input | BYTE_W (8) | Address byte |
| pkt_b1 | input | BYTE_W (8) | Instruction byte |
| pkt_b2 | input | BYTE_W (8) | Error-detection byte |
| cfg_addr | input | ADDR_W (7) | Short address of this locomotive |
| mode_28 | input | 1 | 1: 28-step speed code; 0: 14-step code with headlight bit |
| speed_step | output | STEP_W (5) | Current speed step, 0 = stopped |
| dir_fwd | output | 1 | 1 = forward, 0 = reverse |
| headlight | output | 1 | Headlight state |
| estop | output | 1 | Motor power cut by an emergency stop |

## Verification
Directed packets walk through the end points of each speed table: the lowest and highest moving steps, both stop codes and both emergency-stop codes, with C set and clear. These show whether the extra bit is placed as the LSB and whether the direction-keeping case is limited to C=1. A random mix follows, with the mode chosen per packet. It combines matching and foreign addresses, reset, idle and broadcast stops with either S value, wrong lengths, idle cycles and non-speed instructions. Each packet is compared with a model held in the bench, so that classification errors and leaks of estop or headlight state between modes show up as differences.

// File: rtl/loco_cmd_pkg.sv
package loco_cmd_pkg;
   localparam int PKT_BYTES = 3;
   localparam int DIR_BIT   = 5;
   localparam int AUX_BIT   = 4;

   typedef enum logic [2:0] {
      PK_NONE  = 3'd0,
      PK_RESET = 3'd1,
      PK_IDLE  = 3'd2,
      PK_BSTOP = 3'd3,
      PK_SPEED = 3'd4
   } pkt_kind_t;
endpackage

// File: rtl/loco_pkt_classify.sv
module loco_pkt_classify
   import loco_cmd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 7,
   parameter int LEN_W  = 3
) (
   input  logic              pkt_valid,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic [BYTE_W-1:0] b0,
   input  logic [BYTE_W-1:0] b1,
   input  logic [BYTE_W-1:0] b2,
   input  logic [ADDR_W-1:0] cfg_addr,
   output pkt_kind_t         kind
);
   logic [BYTE_W-1:0]    bytes_q [PKT_BYTES];
   logic [PKT_BYTES-1:0] is_zero;
   logic len_ok, all_zero, idle_hit, bstop_hit, addr_hit, speed_form;

   assign bytes_q[0] = b0;
   assign bytes_q[1] = b1;
   assign bytes_q[2] = b2;

   for (genvar g = 0; g < PKT_BYTES; g++) begin : g_zero
      assign is_zero[g] = (bytes_q[g] == '0);
   end

   assign len_ok     = (pkt_len == LEN_W'(PKT_BYTES));
   assign all_zero   = &is_zero;
   assign speed_form = (b1[BYTE_W-1 -: 2] == 2'b01);
   assign idle_hit   = (b0 == '1) && is_zero[1] && (b2 == '1);
   assign bstop_hit  = is_zero[0] && speed_form && (b1[3:1] == 3'b000);
   assign addr_hit   = !b0[BYTE_W-1] && (b0[ADDR_W-1:0] == cfg_addr) &&
                       (cfg_addr != '0) && speed_form;

   always_comb begin
      kind = PK_NONE;
      if (pkt_valid && len_ok) begin
         if (all_zero)       kind = PK_RESET;
         else if (idle_hit)  kind = PK_IDLE;
         else if (bstop_hit) kind = PK_BSTOP;
         else if (addr_hit)  kind = PK_SPEED;
      end
   end
endmodule

// File: rtl/loco_speed_map.sv
module loco_speed_map
   import loco_cmd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int STEP_W = 5
) (
   input  logic [BYTE_W-1:0] instr,
   input  logic              mode_28,
   output logic [STEP_W-1:0] new_step,
   output logic              est_set,
   output logic              est_clr,
   output logic              dir_load,
   output logic              hl_load
);
   localparam int MAX_STEP = 28;

   logic [4:0] code28;
   logic [3:0] nib;

   assign nib    = instr[3:0];
   assign code28 = {instr[3:0], instr[AUX_BIT]};

   always_comb begin
      new_step = '0;
      est_set  = 1'b0;
      est_clr  = 1'b0;
      dir_load = 1'b1;
      hl_load  = 1'b0;
      if (mode_28) begin
         if (code28 >= 5'd4) begin
            new_step = STEP_W'(code28) - STEP_W'(3);
            est_clr  = 1'b1;
         end else begin
            est_set  = code28[1];
            dir_load = !instr[AUX_BIT];
         end
      end else begin
         hl_load = 1'b1;
         if (nib >= 4'd2) begin
            new_step = STEP_W'(nib) - STEP_W'(1);
            est_clr  = 1'b1;
         end else begin
            est_set = nib[0];
         end
      end
   end

   // R3 / R4: a decoded step never exceeds the 28-step table
   always_comb begin
      a_r3_step_in_table: assert (new_step <= STEP_W'(MAX_STEP));
   end
endmodule

// File: rtl/loco_state_reg.sv
module loco_state_reg
   import loco_cmd_pkg::*;
#(
   parameter int   STEP_W    = 5,
   parameter logic PWRUP_FWD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pkt_kind_t         kind,
   input  logic [STEP_W-1:0] new_step,
   input  logic              est_set,
   input  logic              est_clr,
   input  logic              dir_load,
   input  logic              dir_val,
   input  logic              hl_load,
   input  logic              hl_val,
   input  logic              cut_power,
   output logic [STEP_W-1:0] speed_step,
   output logic              dir_fwd,
   output logic              headlight,
   output logic              estop
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         speed_step <= '0;
         dir_fwd    <= PWRUP_FWD;
         headlight  <= 1'b0;
         estop      <= 1'b0;
      end else begin
         unique case (kind)
            PK_RESET: begin
               speed_step <= '0;
               dir_fwd    <= PWRUP_FWD;
               headlight  <= 1'b0;
               estop      <= 1'b0;
            end
            PK_BSTOP: begin
               speed_step <= '0;
               if (cut_power) estop <= 1'b1;
            end
            PK_SPEED: begin
               speed_step <= new_step;
               if (est_set)      estop <= 1'b1;
               else if (est_clr) estop <= 1'b0;
               if (dir_load) dir_fwd   <= dir_val;
               if (hl_load)  headlight <= hl_val;
            end
            default: ;
         endcase
      end
   end

   a_r5_estop_zero_speed: assert property (@(posedge clk) disable iff (!rst_n)
      estop |-> (speed_step == '0));

   a_r1_ignored_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PK_NONE) |=> ($stable(speed_step) && $stable(dir_fwd) &&
                             $stable(headlight) && $stable(estop)));

   a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PK_IDLE) |=> ($stable(speed_step) && $stable(dir_fwd) &&
                             $stable(headlight) && $stable(estop)));

   a_r6_reset_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PK_RESET) |=> (speed_step == '0 && dir_fwd == PWRUP_FWD &&
                              !headlight && !estop));

   a_r8_bstop_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PK_BSTOP) |=> (speed_step == '0 && $stable(dir_fwd) &&
                              $stable(headlight)));
endmodule

// File: rtl/loco_cmd_decoder.sv
module loco_cmd_decoder
   import loco_cmd_pkg::*;
#(
   parameter int   BYTE_W    = 8,
   parameter int   ADDR_W    = 7,
   parameter int   LEN_W     = 3,
   parameter int   STEP_W    = 5,
   parameter logic PWRUP_FWD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic [BYTE_W-1:0] pkt_b0,
   input  logic [BYTE_W-1:0] pkt_b1,
   input  logic [BYTE_W-1:0] pkt_b2,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              mode_28,
   output logic [STEP_W-1:0] speed_step,
   output logic              dir_fwd,
   output logic              headlight,
   output logic              estop
);
   if (BYTE_W != 8)          $error("BYTE_W must be 8");
   if (ADDR_W != BYTE_W - 1) $error("ADDR_W must be BYTE_W-1");
   if (STEP_W < 5)           $error("STEP_W must hold step 28");
   if ((1 << LEN_W) <= PKT_BYTES) $error("LEN_W too narrow");

   pkt_kind_t         kind;
   logic [STEP_W-1:0] new_step;
   logic              est_set, est_clr, dir_load, hl_load;

   loco_pkt_classify #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_classify (
      .pkt_valid (pkt_valid),
      .pkt_len   (pkt_len),
      .b0        (pkt_b0),
      .b1        (pkt_b1),
      .b2        (pkt_b2),
      .cfg_addr  (cfg_addr),
      .kind      (kind)
   );

   loco_speed_map #(.BYTE_W(BYTE_W), .STEP_W(STEP_W)) u_map (
      .instr    (pkt_b1),
      .mode_28  (mode_28),
      .new_step (new_step),
      .est_set  (est_set),
      .est_clr  (est_clr),
      .dir_load (dir_load),
      .hl_load  (hl_load)
   );

   loco_state_reg #(.STEP_W(STEP_W), .PWRUP_FWD(PWRUP_FWD)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .new_step   (new_step),
      .est_set    (est_set),
      .est_clr    (est_clr),
      .dir_load   (dir_load),
      .dir_val    (pkt_b1[DIR_BIT]),
      .hl_load    (hl_load),
      .hl_val     (pkt_b1[AUX_BIT]),
      .cut_power  (pkt_b1[0]),
      .speed_step (speed_step),
      .dir_fwd    (dir_fwd),
      .headlight  (headlight),
      .estop      (estop)
   );

   // R10: outputs only move on a cycle that carries a packet
   a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> ($stable(speed_step) && $stable(dir_fwd) &&
                      $stable(headlight) && $stable(estop)));
endmodule

// File: tb/loco_cmd_decoder_tb.sv
module loco_cmd_decoder_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_valid = 1'b0;
   logic [2:0] pkt_len = 3'd3;
   logic [7:0] pkt_b0 = '0, pkt_b1 = '0, pkt_b2 = '0;
   logic [6:0] cfg_addr = 7'd5;
   logic       mode_28 = 1'b1;
   logic [4:0] speed_step;
   logic       dir_fwd, headlight, estop;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [4:0] m_spd = '0;
   logic m_dir = 1'b1, m_hl = 1'b0, m_est = 1'b0;

   always #10 clk = ~clk;

   loco_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
      .pkt_b0(pkt_b0), .pkt_b1(pkt_b1), .pkt_b2(pkt_b2), .cfg_addr(cfg_addr),
      .mode_28(mode_28), .speed_step(speed_step), .dir_fwd(dir_fwd),
      .headlight(headlight), .estop(estop));

   task automatic model(input logic v, input logic [2:0] len, input logic [7:0] a,
                        input logic [7:0] i, input logic [7:0] e, input logic m28);
      logic [4:0] code;
      if (!v || len != 3'd3) return;
      if (a == 8'h00 && i == 8'h00 && e == 8'h00) begin
         m_spd = 0; m_dir = 1'b1; m_hl = 0; m_est = 0;
      end else if (a == 8'h00 && i[7:6] == 2'b01 && i[3:1] == 3'b000) begin
         m_spd = 0; if (i[0]) m_est = 1;
      end else if (!a[7] && a[6:0] == cfg_addr && cfg_addr != 0 && i[7:6] == 2'b01) begin
         if (m28) begin
            code = {i[3:0], i[4]};
            if (code >= 4) begin m_spd = code - 5'd3; m_est = 0; end
            else begin m_spd = 0; if (code >= 2) m_est = 1; end
            if (!(code < 4 && i[4])) m_dir = i[5];
         end else begin
            m_hl = i[4]; m_dir = i[5];
            if (i[3:0] >= 2) begin m_spd = 5'(i[3:0]) - 5'd1; m_est = 0; end
            else begin m_spd = 0; if (i[3:0] == 1) m_est = 1; end
         end
      end
   endtask

   task automatic check(input string req, input logic [4:0] s, input logic d,
                        input logic h, input logic e);
      checks++;
      if (speed_step !== s || dir_fwd !== d || headlight !== h || estop !== e) begin
         fails++;
         $display("FAIL %s: got spd=%0d dir=%0b hl=%0b est=%0b, expected spd=%0d dir=%0b hl=%0b est=%0b",
                  req, speed_step, dir_fwd, headlight, estop, s, d, h, e);
      end
   endtask

   task automatic send(input string req, input logic v, input logic [2:0] len,
                       input logic [7:0] a, input logic [7:0] i, input logic [7:0] e,
                       input logic m28);
      @(negedge clk);
      pkt_valid = v; pkt_len = len; pkt_b0 = a; pkt_b1 = i; pkt_b2 = e; mode_28 = m28;
      model(v, len, a, i, e, m28);
      @(negedge clk);
      pkt_valid = 1'b0;
      check(req, m_spd, m_dir, m_hl, m_est);
   endtask

   task automatic pkt(input string req, input logic [7:0] a, input logic [7:0] i,
                      input logic m28);
      send(req, 1'b1, 3'd3, a, i, a ^ i, m28);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R10 reset state", 5'd0, 1'b1, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after reset release", 5'd0, 1'b1, 1'b0, 1'b0);

      pkt("R3 top code step 28", 8'h05, 8'h7F, 1'b1);
      check("R3 step 28", 5'd28, 1'b1, 1'b0, 1'b0);
      pkt("R3 R2 code 4 step 1 reverse", 8'h05, 8'h42, 1'b1);
      check("R2 reverse step 1", 5'd1, 1'b0, 1'b0, 1'b0);
      pkt("R1 other address", 8'h06, 8'h7F, 1'b1);
      send("R1 wrong length", 1'b1, 3'd4, 8'h05, 8'h7F, 8'h7A, 1'b1);
      send("R1 valid low", 1'b0, 3'd3, 8'h05, 8'h7F, 8'h7A, 1'b1);
      pkt("R1 non-speed instruction", 8'h05, 8'h3F, 1'b1);
      check("R1 unchanged", 5'd1, 1'b0, 1'b0, 1'b0);
      pkt("R9 R5 estop code 3 keeps dir", 8'h05, 8'h71, 1'b1);
      check("R9 dir held on C=1 estop", 5'd0, 1'b0, 1'b0, 1'b1);
      pkt("R5 stop code 0 keeps estop", 8'h05, 8'h60, 1'b1);
      check("R5 stop keeps estop", 5'd0, 1'b1, 1'b0, 1'b1);
      pkt("R5 step clears estop", 8'h05, 8'h63, 1'b1);
      check("R5 step 3 clears estop", 5'd3, 1'b1, 1'b0, 1'b0);
      send("R7 idle", 1'b1, 3'd3, 8'hFF, 8'h00, 8'hFF, 1'b1);
      check("R7 idle no change", 5'd3, 1'b1, 1'b0, 1'b0);
      pkt("R8 broadcast cut", 8'h00, 8'h41, 1'b1);
      check("R8 broadcast estop", 5'd0, 1'b1, 1'b0, 1'b1);
      pkt("R5 restart", 8'h05, 8'h63, 1'b1);
      pkt("R8 broadcast stop", 8'h00, 8'h40, 1'b1);
      check("R8 broadcast normal stop", 5'd0, 1'b1, 1'b0, 1'b0);
      pkt("R4 14-step top", 8'h05, 8'h7F, 1'b0);
      check("R4 step 14 headlight on", 5'd14, 1'b1, 1'b1, 1'b0);
      pkt("R4 14-step estop", 8'h05, 8'h41, 1'b0);
      check("R4 estop headlight off", 5'd0, 1'b0, 1'b0, 1'b1);
      pkt("R4 headlight untouched in 28", 8'h05, 8'h72, 1'b0);
      pkt("R4 28 mode with C set", 8'h05, 8'h5F, 1'b1);
      check("R4 headlight kept in 28-step", 5'd28, 1'b0, 1'b1, 1'b0);
      send("R6 reset packet", 1'b1, 3'd3, 8'h00, 8'h00, 8'h00, 1'b1);
      check("R6 power-up state", 5'd0, 1'b1, 1'b0, 1'b0);

      for (int n = 0; n < 600; n++) begin
         logic [7:0] a, i;
         logic m28;
         int sel;
         sel = $urandom_range(0, 9);
         m28 = 1'($urandom);
         i = {2'b01, 6'($urandom)};
         a = {1'b0, cfg_addr};
         case (sel)
            0, 1, 2: pkt("R3 R4 random addressed", a, i, m28);
            3: pkt("R1 random other address", {1'b0, 7'(cfg_addr + 7'($urandom_range(1, 126)))}, i, m28);
            4: send("R7 random idle", 1'b1, 3'd3, 8'hFF, 8'h00, 8'hFF, m28);
            5: if ($urandom_range(0, 3) == 0)
                  send("R6 random reset", 1'b1, 3'd3, 8'h00, 8'h00, 8'h00, m28);
               else
                  pkt("R3 random addressed", a, i, m28);
            6: pkt("R8 random broadcast", 8'h00, {2'b01, 2'($urandom), 3'b000, 1'($urandom)}, m28);
            7: send("R1 random bad length", 1'b1, 3'($urandom_range(0, 2)), a, i, a ^ i, m28);
            8: send("R10 random no valid", 1'b0, 3'd3, a, i, a ^ i, m28);
            default: pkt("R1 random other instr", a, {~i[7:6], i[5:0]}, m28);
         endcase
      end
      finish_run();
   end
endmodule